// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a small up-counter whose state bits all update together on the rising clock edge. It can be forced to zero, preset from a parallel data word, advanced by one, or held. Clear outranks load, load outranks counting, and counting outranks holding. Counting needs two separate enable inputs, and both must be high. One of them, the chain enable, also gates the terminal-count carry. A build-time parameter decides how clear acts. It either waits for the next clock edge or takes effect at once without a clock.

The carry output is high only when the count sits at its all-ones value and the chain enable is high. It is decoded from the registered count, so during normal counting it moves only when the state moves. To build a wider counter, the carry of one stage drives the chain enable of the next stage, and every stage shares the clock, the count enable, the load and the clear. With the edge-timed clear, decoding a chosen count N outside the block and feeding the result back to clear shortens the count cycle to the values 0 through N.

Top module: `preset_counter`

## Requirements
- R1: With clear and load both inactive (high) and both enables high, the count rises by exactly one on each rising clock edge. All bits update on that same edge, and the all-ones value is followed by zero.
- R2: With clear and load both inactive, the count keeps its value across a clock edge whenever either enable is low.
- R3: With clear inactive and load low, the next rising edge copies the data input into the count, whatever the enable levels are.
- R4: Clear low takes priority over load and over both enables. After a clock edge with clear low, the count reads zero.
- R5: In the default build (CLR_ASYNC = 0), pulling clear low leaves the count unchanged until the next rising edge.
- R6: In the build with CLR_ASYNC = 1, pulling clear low sets the count to zero at once, with no clock edge needed.
- R7: The carry output is high exactly when the count is all ones and the chain enable is high. It never changes while both the count and the chain enable are steady.
- R8: Two 4-bit instances form an 8-bit synchronous counter when the low stage's carry drives the high stage's chain enable and the two stages share clock, count enable, load and clear. The high stage then advances only on the edge where the low stage wraps.
- R9: In the default build, feeding back an external decode of count N to clear makes the counter repeat the N+1 values 0, 1, ..., N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear. Edge-timed or immediate, set by CLR_ASYNC |
| load_n | input | 1 | Active-low parallel preset |
| cnt_en | input | 1 | Count enable |
| chain_en | input | 1 | Chain enable. Also gates the carry |
| din | input | WIDTH | Preset data word |
| q | output | WIDTH | Registered count |
| term_carry | output | 1 | Terminal-count carry for cascading |

## Verification
On every cycle the assertions check several rules. Load copies the data word, a count step adds one, a hold leaves the count unchanged, and clear yields zero. The carry together with the count enable wraps the count to zero, and the carry never moves unless the count or the chain enable moved. Some behaviours are visible only in the bench's scenarios. One is where a clear takes effect within a cycle, immediately in one build and at the edge in the other. The others are the carry handoff between two chained stages across the 8-bit range and the shortened cycle produced by external clear feedback.

// File: rtl/preset_counter_pkg.sv
package preset_counter_pkg;

    // Next-state operation, highest priority first in the selector
    typedef enum logic [1:0] {
        NX_HOLD  = 2'd0,
        NX_COUNT = 2'd1,
        NX_LOAD  = 2'd2,
        NX_CLEAR = 2'd3
    } nx_op_e;

endpackage

// File: rtl/preset_counter_ctrl.sv
module preset_counter_ctrl
    import preset_counter_pkg::*;
(
    input  logic   clr_n,
    input  logic   load_n,
    input  logic   cnt_en,
    input  logic   chain_en,
    output nx_op_e op
);

    // Fixed priority: clear, preset, count, hold
    always_comb begin
        if (!clr_n)
            op = NX_CLEAR;
        else if (!load_n)
            op = NX_LOAD;
        else if (cnt_en && chain_en)
            op = NX_COUNT;
        else
            op = NX_HOLD;
    end

endmodule

// File: rtl/preset_counter_carry.sv
module preset_counter_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             chain_en,
    output logic             carry
);

    // Decoded only from registered state and a level input, so it cannot spike mid-count
    assign carry = chain_en & (&cnt);

endmodule

// File: rtl/preset_counter_core.sv
module preset_counter_core
    import preset_counter_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit CLR_ASYNC = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  nx_op_e           op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            NX_CLEAR: st_d.cnt = '0;
            NX_LOAD:  st_d.cnt = din;
            NX_COUNT: st_d.cnt = st_q.cnt + WIDTH'(1);
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    generate
        if (CLR_ASYNC) begin : g_clr_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    st_q <= '0;
                else
                    st_q <= st_d;
            end
        end else begin : g_clr_sync
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign cnt = st_q.cnt;

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (op == NX_LOAD) |=> (cnt == $past(din)));

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (op == NX_COUNT) |=> (cnt == $past(cnt) + WIDTH'(1)));

    // R2
    hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (op == NX_HOLD) |=> $stable(cnt));

endmodule

// File: rtl/preset_counter.sv
module preset_counter
    import preset_counter_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit CLR_ASYNC = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             term_carry
);

    nx_op_e op;

    preset_counter_ctrl u_ctrl (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .op       (op)
    );

    preset_counter_core #(
        .WIDTH     (WIDTH),
        .CLR_ASYNC (CLR_ASYNC)
    ) u_core (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .din   (din),
        .cnt   (q)
    );

    preset_counter_carry #(
        .WIDTH (WIDTH)
    ) u_carry (
        .cnt      (q),
        .chain_en (chain_en),
        .carry    (term_carry)
    );

    // R4
    clear_zero_chk: assert property (@(posedge clk)
        !clr_n |=> (q == '0));

    // R1
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && term_carry) |=> (q == '0));

    // R7
    carry_quiet_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!$stable(term_carry) && $stable(chain_en)) |-> !$stable(q));

endmodule

// File: tb/sim_preset_counter.sv
`timescale 1ns/1ps
module sim_preset_counter;

    localparam logic [7:0] MOD_N = 8'd5;

    typedef struct {
        logic [7:0] cnt;
        logic       cy;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    // cascaded pair, edge-timed clear
    logic       clr_drv  = 1'b0;
    logic       mod_on   = 1'b0;
    logic       load_n   = 1'b1;
    logic       en       = 1'b0;
    logic       chain    = 1'b0;
    logic [7:0] din      = 8'h00;
    logic [3:0] q_lo, q_hi;
    logic       cy_lo, cy_hi;
    logic [7:0] cnt8;
    logic       clr_n;

    assign cnt8  = {q_hi, q_lo};
    assign clr_n = mod_on ? (cnt8 != MOD_N) : clr_drv;

    preset_counter #(.WIDTH(4), .CLR_ASYNC(1'b0)) u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(en), .chain_en(chain),
        .din(din[3:0]), .q(q_lo), .term_carry(cy_lo));

    preset_counter #(.WIDTH(4), .CLR_ASYNC(1'b0)) u1 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(en), .chain_en(cy_lo),
        .din(din[7:4]), .q(q_hi), .term_carry(cy_hi));

    // immediate-clear build
    logic       a_clr_n  = 1'b0;
    logic       a_load_n = 1'b1;
    logic       a_en     = 1'b0;
    logic [3:0] a_din    = 4'h0;
    logic [3:0] a_q;
    logic       a_cy;

    preset_counter #(.WIDTH(4), .CLR_ASYNC(1'b1)) u2 (
        .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .cnt_en(a_en), .chain_en(a_en),
        .din(a_din), .q(a_q), .term_carry(a_cy));

    // reference model, from the requirements
    logic [3:0] m_lo = 4'h0;
    logic [3:0] m_hi = 4'h0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic l, input logic e, input logic t,
                         input logic [7:0] d, input string req);
        exp_t it;
        logic ce, lo_tc;
        @(negedge clk);
        clr_drv = c; load_n = l; en = e; chain = t; din = d;
        ce    = mod_on ? ({m_hi, m_lo} != MOD_N) : c;
        lo_tc = (m_lo == 4'hF) && t;
        if (!ce) begin
            m_lo = 4'h0; m_hi = 4'h0;
        end else if (!l) begin
            m_lo = d[3:0]; m_hi = d[7:4];
        end else if (e) begin
            if (t)     m_lo = m_lo + 4'd1;
            if (lo_tc) m_hi = m_hi + 4'd1;
        end
        it.cnt = {m_hi, m_lo};
        it.cy  = (m_hi == 4'hF) && (m_lo == 4'hF) && t;
        it.req = req;
        sb_q.push_back(it);
    endtask

    // monitor: compares one expected item per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                check(it.req, int'(cnt8), int'(it.cnt));
                check({it.req, " carry"}, int'(cy_hi), int'(it.cy));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R4: clear beats an active load and enables
        repeat (3) drive(1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, "R4");
        @(negedge clk);
        check("R4 reset state", int'(cnt8), 0);

        // R1 R8: plain counting across the low-stage wrap
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R8");

        // R2: either enable low holds
        repeat (3) drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R2");
        repeat (3) drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R2");

        // R3: preset with enables low, then chain low at all ones
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'hFE, "R3");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1");
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R7");
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R7");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1");

        // R8: carry handoff into the high stage
        drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h2E, "R3");
        repeat (4) drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R8");

        // R5: edge-timed clear waits for the edge
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h37, "R3");
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R5");
        #1;
        check("R5 before edge", int'(cnt8), 8'h37);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R5");

        // R9: modulus by feedback clear
        @(negedge clk);
        mod_on = 1'b1;
        for (int i = 0; i < 14; i++) drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R9");
        repeat (2) @(negedge clk);
        mod_on = 1'b1;
        check("R9 queue drained", sb_q.size(), 0);
        mod_on = 1'b0;
        clr_drv = 1'b1; en = 1'b0;

        // R6: immediate clear build
        @(negedge clk);
        a_clr_n = 1'b1; a_en = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 async build count", int'(a_q), 5);
        #0.5;
        a_clr_n = 1'b0; a_load_n = 1'b0; a_din = 4'h9;
        #0.5;
        check("R6 immediate clear", int'(a_q), 0);
        @(negedge clk);
        check("R4 async clear over load", int'(a_q), 0);
        a_clr_n = 1'b1;
        @(negedge clk);
        check("R3 async load", int'(a_q), 9);
        a_din = 4'hF; a_en = 1'b0;
        @(negedge clk);
        check("R7 carry chain low", int'(a_cy), 0);
        a_en = 1'b1;
        #0.5;
        check("R7 carry at all ones", int'(a_cy), 1);
        a_load_n = 1'b1;
        @(negedge clk);
        check("R1 async wrap", int'(a_q), 0);
        check("R7 carry after wrap", int'(a_cy), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule